// File: doc/BRIEF.md
# Flash Line Buffer

This block sits between a processor read port and a slow on-chip flash array whose rows are 128 bits wide. It keeps the most recently fetched row in a line latch, marked with a tag and a valid bit. A mode setting decides whether a hit is returned at once or only after the programmed fetch time. A fetch-time setting gives the number of clocks that each array read takes. A statistics counter counts array-level accesses, and it can be cleared, started and frozen.

The array read is modelled as asynchronous. The block holds the array strobe and the row address for the whole fetch time. On the last clock of that time it takes the row and raises ready toward the processor. If the program/erase controller reports the array busy during a fetch, the row reads as all ones. That row is latched like any other and keeps being served from the latch after busy clears. The block is truly out of the path only when the mode is off or partial and the fetch time is one clock. In that case every read goes to the array and nothing is latched.

Register writes use `cfg_sel`. Select 0 is the mode: 0 is off, 1 is partial and acts like off, 2 and 3 are full. Select 1 is the fetch time, with a value of 0 read as 1. Select 2 is statistics control: bit 0 is run and bit 1 is clear.

Top module: `flash_line_buffer`

## Requirements
- R1: After reset the line latch is invalid, the mode is off, the fetch time is 7, the statistics counter is 0 and stopped, and `cpu_ready` and `fl_req` are low while no read is requested.
- R2: A read that fetches from the array holds `fl_req` high for exactly T cycles and holds `cpu_ready` low for exactly T-1 cycles before one ready cycle. T is the effective fetch time.
- R3: In full mode (mode 2 or 3), a read whose line tag matches a valid latched line completes in its first cycle without strobing the array. Repeated reads of one line make exactly one array fetch.
- R4: In off or partial mode with T greater than 1, a hit returns the latched word only after T-1 not-ready cycles and does not strobe the array. It still adds one to the statistics counter.
- R5: In off or partial mode with T equal to 1, every read strobes the array for one cycle and returns the array word in that cycle. The line latch is not loaded, so a change of array contents is visible on the next read.
- R6: A fetch made while `fl_busy` is high returns 32'hFFFFFFFF. Unless the read is bypassed (R5), that all-ones line is latched and returned on later hits after busy clears, until a fetch of another line refills the latch.
- R7: A write to select 0 (mode) or select 1 (fetch time) invalidates the latched line, so the next read of that line fetches from the array.
- R8: A fetch-time value of 0 behaves exactly as 1.
- R9: The statistics counter adds one at the end of each read that is not a zero-wait full-mode hit, but only while run (select 2, bit 0) is set. Writing bit 1 of select 2 sets it to 0, and with run clear it holds its value.
- R10: The line tag is `cpu_addr[31:4]`, which is also `fl_addr`. `cpu_addr[3:2]` picks the 32-bit word of the line, with word i at bits 32*i+31 down to 32*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request, held until ready |
| cpu_addr | input | 32 | Byte address of the read |
| cpu_ready | output | 1 | Read completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid while ready |
| fl_req | output | 1 | Array read strobe, held for the fetch time |
| fl_addr | output | 28 | Line address to the array |
| fl_rdata | input | 128 | Array row |
| fl_busy | input | 1 | Program/erase in progress |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 fetch time, 2 statistics control |
| cfg_wdata | input | 8 | Register write data |
| stat_count | output | 32 | Statistics counter |

## Verification
Some rules are checked on every cycle:
- a request never waits longer than T-1 cycles, and every fetch completes after exactly T-1 waits;
- full-mode hits finish at once without a strobe;
- a bypassed read is a one-cycle strobe;
- busy fetches return all ones;
- register writes clear the valid bit;
- a stopped counter does not move.

Only the scenarios can show the data side. This covers the staleness of a latched busy line until a refill, the new array contents seen through the bypass, the word picked from the address, and the exact counter totals across mode changes.

// File: rtl/flb_pkg.sv
package flb_pkg;
   localparam logic [1:0] SEL_MODE = 2'd0;
   localparam logic [1:0] SEL_TIME = 2'd1;
   localparam logic [1:0] SEL_STAT = 2'd2;

   localparam logic [1:0] MODE_OFF  = 2'd0;
   localparam logic [1:0] MODE_PART = 2'd1;
   localparam logic [1:0] MODE_FULL = 2'd2;

   // Modes 2 and 3 both serve hits without waiting.
   function automatic logic mode_is_full(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/flb_wsel.sv
module flb_wsel #(
   parameter int LINE_W = 128,
   parameter int DATA_W = 32,
   localparam int WORDS = LINE_W / DATA_W,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic [LINE_W-1:0] line,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   generate
      if (WORDS == 1) begin : g_single
         logic unused_idx;
         assign unused_idx = ^idx;
         assign word = line;
      end else begin : g_multi
         logic [DATA_W-1:0] words [WORDS];
         for (genvar i = 0; i < WORDS; i++) begin : g_split
            assign words[i] = line[i*DATA_W +: DATA_W];
         end
         assign word = words[idx];
      end
   endgenerate
endmodule

// File: rtl/flb_pacer.sv
module flb_pacer #(
   parameter int TIM_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [TIM_W-1:0] t_eff,
   output logic             last
);
   logic [TIM_W-1:0] cnt_q;

   assign last = (cnt_q == TIM_W'(t_eff - TIM_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + TIM_W'(1);
      end
   end
endmodule

// File: rtl/flb_line.sv
module flb_line #(
   parameter int LINE_W = 128,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 28,
   localparam int WORDS = LINE_W / DATA_W,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval,
   input  logic              load,
   input  logic [TAG_W-1:0]  load_tag,
   input  logic [LINE_W-1:0] load_line,
   input  logic [TAG_W-1:0]  look_tag,
   input  logic [IDX_W-1:0]  idx,
   output logic              hit,
   output logic [DATA_W-1:0] rd_word,
   output logic              valid_q,
   output logic [TAG_W-1:0]  tag_q
);
   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         line_q  <= '0;
      end else if (inval) begin
         valid_q <= 1'b0;
      end else if (load) begin
         valid_q <= 1'b1;
         tag_q   <= load_tag;
         line_q  <= load_line;
      end
   end

   assign hit = valid_q && (tag_q == look_tag);

   flb_wsel #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_sel (
      .line (line_q),
      .idx  (idx),
      .word (rd_word)
   );
endmodule

// File: rtl/flb_stats.sv
module flb_stats #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             ctl_run,
   input  logic             ctl_clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             run_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         run_q <= 1'b0;
      end else begin
         if (ctl_we) run_q <= ctl_run;
         if (ctl_we && ctl_clr) count <= '0;
         else if (run_q && inc) count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/flash_line_buffer.sv
module flash_line_buffer
   import flb_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int LINE_W  = 128,
   parameter int TIM_W   = 3,
   parameter int TIM_RST = 7,
   parameter int CNT_W   = 32,
   localparam int OFF_W  = $clog2(LINE_W / 8),
   localparam int BYTE_W = $clog2(DATA_W / 8),
   localparam int TAG_W  = ADDR_W - OFF_W,
   localparam int WORDS  = LINE_W / DATA_W,
   localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              fl_req,
   output logic [TAG_W-1:0]  fl_addr,
   input  logic [LINE_W-1:0] fl_rdata,
   input  logic              fl_busy,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic [CNT_W-1:0]  stat_count
);
   generate
      if (LINE_W % DATA_W != 0 || DATA_W % 8 != 0) begin : g_bad_width
         $error("flash_line_buffer: LINE_W must be a multiple of DATA_W, DATA_W of 8");
      end
      if ((LINE_W & (LINE_W - 1)) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_pow2
         $error("flash_line_buffer: LINE_W and DATA_W must be powers of two");
      end
      if (TIM_W < 1 || TIM_W > 8 || TIM_RST >= (1 << TIM_W)) begin : g_bad_tim
         $error("flash_line_buffer: fetch time field does not fit");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("flash_line_buffer: ADDR_W too small for one line");
      end
   endgenerate

   logic [1:0]       mode_q;
   logic [TIM_W-1:0] tim_q;
   logic [TIM_W-1:0] t_eff;
   logic             full, bypass, hit, fast, from_latch, last, fetch;
   logic             line_valid;
   logic [TAG_W-1:0] line_tag, look_tag;
   logic [IDX_W-1:0] idx;
   logic [DATA_W-1:0] latch_word, array_word, fetched_word;
   logic [LINE_W-1:0] fetched_line;
   logic             stat_run;
   logic             inval;
   logic             unused_bits;

   assign unused_bits = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         tim_q  <= TIM_W'(TIM_RST);
      end else if (cfg_we) begin
         if (cfg_sel == SEL_MODE) mode_q <= cfg_wdata[1:0];
         if (cfg_sel == SEL_TIME) tim_q  <= cfg_wdata[TIM_W-1:0];
      end
   end

   assign t_eff   = (tim_q == '0) ? TIM_W'(1) : tim_q;
   assign full    = mode_is_full(mode_q);
   assign bypass  = !full && (t_eff == TIM_W'(1));
   assign inval   = cfg_we && (cfg_sel == SEL_MODE || cfg_sel == SEL_TIME);

   assign look_tag = cpu_addr[ADDR_W-1:OFF_W];
   assign idx      = IDX_W'(cpu_addr >> BYTE_W);
   assign fl_addr  = look_tag;

   assign fast       = full && hit;
   assign from_latch = hit && !bypass;
   assign fetch      = cpu_req && !from_latch;
   assign fl_req     = fetch;

   flb_pacer #(.TIM_W(TIM_W)) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (cpu_req && !fast),
      .t_eff  (t_eff),
      .last   (last)
   );

   assign fetched_line = fl_busy ? {LINE_W{1'b1}} : fl_rdata;

   flb_wsel #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_arr_sel (
      .line (fetched_line),
      .idx  (idx),
      .word (array_word)
   );

   flb_line #(.LINE_W(LINE_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .inval     (inval),
      .load      (fetch && last && !bypass),
      .load_tag  (look_tag),
      .load_line (fetched_line),
      .look_tag  (look_tag),
      .idx       (idx),
      .hit       (hit),
      .rd_word   (latch_word),
      .valid_q   (line_valid),
      .tag_q     (line_tag)
   );

   assign fetched_word = array_word;
   assign cpu_ready    = cpu_req && (fast || last);
   assign cpu_rdata    = from_latch ? latch_word : fetched_word;

   flb_stats #(.CNT_W(CNT_W)) u_stats (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_we  (cfg_we && cfg_sel == SEL_STAT),
      .ctl_run (cfg_wdata[0]),
      .ctl_clr (cfg_wdata[1]),
      .inc     (cpu_req && !fast && last),
      .count   (stat_count),
      .run_q   (stat_run)
   );
endmodule

// File: rtl/flash_line_buffer_chk.sv
module flash_line_buffer_chk
   import flb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int TIM_W  = 3,
   parameter int CNT_W  = 32,
   parameter int TAG_W  = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              fl_req,
   input logic              fl_busy,
   input logic              cfg_we,
   input logic [1:0]        cfg_sel,
   input logic [1:0]        mode_q,
   input logic [TIM_W-1:0]  tim_q,
   input logic              line_valid,
   input logic [TAG_W-1:0]  line_tag,
   input logic [CNT_W-1:0]  stat_count,
   input logic              stat_run
);
   logic [15:0] wcnt;
   logic [15:0] t_lim;
   logic        tag_match;

   assign t_lim     = (tim_q == '0) ? 16'd1 : 16'(tim_q);
   assign tag_match = line_valid && (line_tag == cpu_addr[ADDR_W-1:ADDR_W-TAG_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) wcnt <= '0;
      else if (cpu_req && !cpu_ready) wcnt <= wcnt + 16'd1;
      else wcnt <= '0;
   end

   // R2: never more than T-1 waits
   p_wait_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_ready) |-> (wcnt + 16'd1 < t_lim));

   // R2: a fetch completes after exactly T-1 waits
   p_fetch_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && fl_req) |-> (wcnt == t_lim - 16'd1));

   // R3: full-mode hit is immediate and does not touch the array
   p_fast_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && mode_is_full(mode_q) && tag_match) |-> (cpu_ready && !fl_req));

   // R5: bypass is a single strobed cycle
   p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !mode_is_full(mode_q) && t_lim == 16'd1) |-> (cpu_ready && fl_req));

   // R6: busy fetch returns all ones
   p_busy_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && fl_req && fl_busy) |-> (cpu_rdata == '1));

   // R7: mode or fetch time write clears the valid bit
   p_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_sel == SEL_MODE || cfg_sel == SEL_TIME)) |=> !line_valid);

   // R9: a stopped counter holds
   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_run && !(cfg_we && cfg_sel == SEL_STAT)) |=> $stable(stat_count));
endmodule

bind flash_line_buffer flash_line_buffer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIM_W(TIM_W), .CNT_W(CNT_W), .TAG_W(TAG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_addr   (cpu_addr),
   .cpu_ready  (cpu_ready),
   .cpu_rdata  (cpu_rdata),
   .fl_req     (fl_req),
   .fl_busy    (fl_busy),
   .cfg_we     (cfg_we),
   .cfg_sel    (cfg_sel),
   .mode_q     (mode_q),
   .tim_q      (tim_q),
   .line_valid (line_valid),
   .line_tag   (line_tag),
   .stat_count (stat_count),
   .stat_run   (stat_run)
);

// File: tb/tb_flash_line_buffer.sv
module tb_flash_line_buffer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0;
   logic [31:0]  cpu_addr = '0;
   logic         cpu_ready;
   logic [31:0]  cpu_rdata;
   logic         fl_req;
   logic [27:0]  fl_addr;
   logic [127:0] fl_rdata;
   logic         fl_busy = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = '0;
   logic [7:0]   cfg_wdata = '0;
   logic [31:0]  stat_count;

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   logic [7:0] gen = 8'd1;
   int  exp_stat = 0;
   bit  run_b = 0;

   function automatic logic [31:0] aw(input logic [27:0] ln, input logic [1:0] w,
                                      input logic [7:0] g);
      return {g, ln[19:0], 2'b00, w};
   endfunction

   for (genvar i = 0; i < 4; i++) begin : g_arr
      assign fl_rdata[i*32 +: 32] = aw(fl_addr, 2'(i), gen);
   end

   flash_line_buffer dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .fl_req(fl_req),
      .fl_addr(fl_addr), .fl_rdata(fl_rdata), .fl_busy(fl_busy),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .stat_count(stat_count)
   );

   typedef struct {
      logic [31:0] data;
      int          waits;
      int          strobes;
      string       rq;
   } exp_t;
   exp_t sbq[$];

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", rq, act, exp);
      end
   endtask

   // monitor: counts waits and strobes, compares at each completion
   int mon_waits = 0;
   int mon_strobes = 0;
   always @(negedge clk) begin
      #3;
      if (cpu_req) begin
         if (fl_req) mon_strobes++;
         if (cpu_ready) begin
            if (sbq.size() == 0) begin
               checks++; errors++;
               $display("FAIL unexpected completion actual %h expected none", cpu_rdata);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               check({e.rq, " data"}, cpu_rdata, e.data);
               check({e.rq, " waits"}, 32'(mon_waits), 32'(e.waits));
               check({e.rq, " strobes"}, 32'(mon_strobes), 32'(e.strobes));
            end
            mon_waits = 0;
            mon_strobes = 0;
         end else begin
            mon_waits++;
         end
      end
   end

   function automatic logic [31:0] ed(input logic [31:0] a);
      return aw(a[31:4], a[3:2], gen);
   endfunction

   task automatic rd(input logic [31:0] a, input logic [31:0] d, input int ew,
                     input int es, input string rq);
      exp_t e;
      e.data = d; e.waits = ew; e.strobes = es; e.rq = rq;
      sbq.push_back(e);
      @(negedge clk);
      cpu_addr = a;
      cpu_req  = 1'b1;
      #2;
      while (!cpu_ready) begin
         @(negedge clk);
         #2;
      end
      @(posedge clk);
      #1 cpu_req = 1'b0;
      if (run_b && (ew > 0 || es > 0)) exp_stat++;
   endtask

   task automatic cfg(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
      @(posedge clk);
      #1 cfg_we = 1'b0;
      if (s == 2'd2) begin
         if (v[1]) exp_stat = 0;
         run_b = v[0];
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ready", 32'(cpu_ready), 0);
      check("R1 strobe", 32'(fl_req), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 count", stat_count, 0);

      cfg(2'd2, 8'h03);
      // R2: miss at reset fetch time 7; R1 latch invalid
      rd(32'h100, ed(32'h100), 6, 7, "R2 fetch T7");
      // R4: stretched hit in off mode
      rd(32'h104, ed(32'h104), 6, 0, "R4 stretched hit");
      check("R4 count", stat_count, 32'(exp_stat));

      // R7: timing write invalidates
      cfg(2'd1, 8'd3);
      rd(32'h104, ed(32'h104), 2, 3, "R7 refetch after time write");
      rd(32'h10C, ed(32'h10C), 2, 0, "R4 hit T3");

      // R3: full mode, R7 mode write invalidates
      cfg(2'd0, 8'd2);
      rd(32'h104, ed(32'h104), 2, 3, "R7 refetch after mode write");
      rd(32'h200, ed(32'h200), 2, 3, "R2 fetch T3");
      rd(32'h208, ed(32'h208), 0, 0, "R3 fast hit R10 word2");
      rd(32'h20C, ed(32'h20C), 0, 0, "R3 fast hit R10 word3");
      rd(32'h20C, ed(32'h20C), 0, 0, "R3 repeat");
      rd(32'h204, ed(32'h204), 0, 0, "R3 repeat R10 word1");
      check("R3 count", stat_count, 32'(exp_stat));

      // R6: busy fetch latched as all ones
      fl_busy = 1'b1;
      rd(32'h300, 32'hFFFF_FFFF, 2, 3, "R6 busy fetch");
      fl_busy = 1'b0;
      rd(32'h304, 32'hFFFF_FFFF, 0, 0, "R6 stale hit");
      rd(32'h400, ed(32'h400), 2, 3, "R6 refill other");
      rd(32'h300, ed(32'h300), 2, 3, "R6 refetch clean");

      // R4: partial mode behaves like off
      cfg(2'd0, 8'd1);
      rd(32'h600, ed(32'h600), 2, 3, "R4 partial miss");
      rd(32'h608, ed(32'h608), 2, 0, "R4 partial hit");

      // R5: bypass
      cfg(2'd0, 8'd0);
      cfg(2'd1, 8'd1);
      rd(32'h500, ed(32'h500), 0, 1, "R5 bypass");
      gen = 8'd2;
      rd(32'h500, ed(32'h500), 0, 1, "R5 new contents");
      fl_busy = 1'b1;
      rd(32'h500, 32'hFFFF_FFFF, 0, 1, "R6 busy bypass");
      fl_busy = 1'b0;
      rd(32'h500, ed(32'h500), 0, 1, "R5 not latched");

      // R8: fetch time 0 acts as 1
      cfg(2'd1, 8'd0);
      rd(32'h700, ed(32'h700), 0, 1, "R8 bypass T0");
      cfg(2'd0, 8'd2);
      rd(32'h800, ed(32'h800), 0, 1, "R8 full miss T0");
      rd(32'h804, ed(32'h804), 0, 0, "R8 full hit T0");
      check("R9 count", stat_count, 32'(exp_stat));

      // R9: freeze, clear, restart
      cfg(2'd2, 8'h00);
      cfg(2'd0, 8'd0);
      rd(32'h900, ed(32'h900), 0, 1, "R9 read frozen");
      check("R9 frozen", stat_count, 32'(exp_stat));
      cfg(2'd2, 8'h02);
      check("R9 clear", stat_count, 0);
      cfg(2'd2, 8'h01);
      rd(32'h900, ed(32'h900), 0, 1, "R9 read run");
      check("R9 run", stat_count, 1);

      repeat (3) @(negedge clk);
      check("scoreboard empty", 32'(sbq.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule